// File: doc/BRIEF.md
# Host Command and Status Port

This block is the host-facing front end of a multi-channel playback engine. A host microcontroller writes command and subcommand bytes into it. It does this either over an 8-bit parallel bus or as a clocked serial stream, and a static mode input picks which one. Each accepted byte leaves the port as a single-cycle pulse toward the command decoder. The pulse carries the byte and a tag that says whether the byte was a command or a subcommand.

The same port also returns per-channel status to the host. A select input chooses between two status vectors:

- a ready vector, where high means the channel can take its next command;
- an active-low busy vector, which is low while the channel plays.

In parallel mode the chosen vector goes out on a read bus while the read strobe is low. In serial mode the host can shift the vector out through a single serial output pin. Also in serial mode, four status pins always show one half of the channels.

All host strobes are assumed to be already synchronous to the block clock. The block samples each of them once per cycle and acts on the edges it finds.

The outgoing byte stream has no back-pressure. The decoder must take every pulse in the cycle it appears. A new pulse can only follow after a fresh low phase of the write strobe.

Top module: `host_cmd_port`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `byte_valid`, `pdata_oe`, `pdata_out`, `sout` and `snib` are all zero.
- R2: In parallel mode (`ser_mode`=0), a rising edge of `wr_n` with `cs_n` low is followed one clock later by a one-cycle `byte_valid`. In that cycle `byte_data` equals `pdata_in`, and `byte_is_sub` equals `cmd_sel` (1 = subcommand, 0 = command).
- R3: A rising edge of `wr_n` while `cs_n` is high produces no `byte_valid`, and `byte_data` keeps its previous value.
- R4: In serial mode (`ser_mode`=1), with `cs_n` low and `rd_n` high, each rising edge of `sclk` shifts `sdata` into the receive register, first bit into the most significant position. A write edge then delivers that register, and `pdata_in` has no effect.
- R5: A write edge after k<8 serial bits delivers those k bits right-aligned, with the upper bits zero. A cycle with `cs_n` high discards all bits gathered so far, and so does an accepted byte.
- R6: Serial clock edges after the eighth bit of a byte are ignored, so the first eight bits are delivered.
- R7: In parallel mode, one cycle after `rd_n` goes low, `pdata_oe` is 1 and `pdata_out[i]` carries the status of channel i+1 (bit 7 = channel 8). One cycle after `rd_n` returns high, `pdata_oe` and `pdata_out` are 0.
- R8: `stat_sel`=1 selects `ch_ready` as the status vector. `stat_sel`=0 selects `ch_busy_n`.
- R9: In serial mode, when `rd_n` and `cs_n` are both low, the status vector is captured. `sout` shows channel 8 one cycle later and moves down one channel after each `sclk` rising edge. Status changes during the read do not alter the captured vector. Outside a read, `sout` is 0.
- R10: In serial mode, one cycle after any input change, `snib` shows channels 8..5 when `grp_hi`=1 and channels 4..1 when `grp_hi`=0, with `snib[3]` the highest channel of the group. In parallel mode `snib` is 0.
- R11: `byte_valid` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode | input | 1 | 1 = serial host interface, 0 = parallel |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; its rising edge accepts a byte |
| rd_n | input | 1 | Active-low read strobe |
| cmd_sel | input | 1 | 1 = subcommand byte, 0 = command byte |
| pdata_in | input | 8 | Parallel write data |
| sdata | input | 1 | Serial write data |
| sclk | input | 1 | Serial shift clock, sampled |
| grp_hi | input | 1 | Selects the channel half shown on `snib` |
| stat_sel | input | 1 | 1 = ready status, 0 = busy status |
| ch_ready | input | 8 | Per-channel ready flags, active high |
| ch_busy_n | input | 8 | Per-channel busy flags, low while playing |
| byte_valid | output | 1 | One-cycle pulse marking a delivered byte |
| byte_data | output | 8 | Delivered byte |
| byte_is_sub | output | 1 | Tag of the delivered byte |
| pdata_out | output | 8 | Parallel status read data |
| pdata_oe | output | 1 | Drive enable for the parallel read bus |
| sout | output | 1 | Serial status output |
| snib | output | 4 | Always-on status half in serial mode |

## Verification
Every result of this block is registered exactly once. `byte_valid` follows the cycle in which `wr_n` is first seen high. The read bus, `snib` and the serial status bit follow the cycle in which their inputs change, or the cycle of the `sclk` rise that advanced them.

The bench drives all inputs just after a falling clock edge and reads outputs at the next falling edge. That puts exactly one rising edge between a stimulus and its check. Single-cycle behaviours, such as the write pulse collapsing, are checked one falling edge later again.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

  parameter int unsigned HP_BYTE_W = 8;
  parameter int unsigned HP_NCH    = 8;

  typedef enum logic {
    TAG_CMD = 1'b0,
    TAG_SUB = 1'b1
  } byte_tag_e;

  // indices into the strobe vector handed to the edge detector
  localparam int unsigned STB_WR   = 0;
  localparam int unsigned STB_SCLK = 1;
  localparam int unsigned STB_N    = 2;

endpackage

// File: rtl/hp_edge_det.sv
module hp_edge_det #(
  parameter int unsigned N       = 2,
  parameter logic [N-1:0] RST_LVL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= RST_LVL[g];
      else        prev_q[g] <= lvl[g];
    end
    assign rise[g] = ~prev_q[g] & lvl[g];
  end

endmodule

// File: rtl/hp_ser_rx.sv
module hp_ser_rx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              shift_evt,
  input  logic              sd,
  input  logic              take,
  output logic [BYTE_W-1:0] shreg
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0] cnt_q;
  logic             room;

  assign room = (cnt_q < CNT_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt_q <= '0;
    end else if (!en || cs_n || take) begin
      shreg <= '0;
      cnt_q <= '0;
    end else if (shift_evt && rd_n && room) begin
      shreg <= {shreg[BYTE_W-2:0], sd};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_clr_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt_q == '0));

endmodule

// File: rtl/hp_stat_out.sv
module hp_stat_out #(
  parameter int unsigned NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_mode,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             shift_evt,
  input  logic             stat_sel,
  input  logic             grp_hi,
  input  logic [NCH-1:0]   ready,
  input  logic [NCH-1:0]   busy_n,
  output logic [NCH-1:0]   pdata_out,
  output logic             pdata_oe,
  output logic             sout,
  output logic [NCH/2-1:0] snib
);

  localparam int unsigned HALF = NCH / 2;

  logic [NCH-1:0]  stat;
  logic [HALF-1:0] half_sel;
  logic            par_rd, ser_rd, rd_act_q;
  logic [NCH-1:0]  oreg_q;

  assign stat     = stat_sel ? ready : busy_n;
  assign half_sel = grp_hi ? stat[NCH-1 -: HALF] : stat[HALF-1:0];
  assign par_rd   = !ser_mode && !rd_n;
  assign ser_rd   = ser_mode && !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdata_oe  <= 1'b0;
      pdata_out <= '0;
      snib      <= '0;
    end else begin
      pdata_oe  <= par_rd;
      pdata_out <= par_rd ? stat : '0;
      snib      <= ser_mode ? half_sel : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      oreg_q   <= '0;
    end else begin
      rd_act_q <= ser_rd;
      if (ser_rd && !rd_act_q)
        oreg_q <= stat;
      else if (ser_rd && shift_evt)
        oreg_q <= {oreg_q[NCH-2:0], 1'b0};
    end
  end

  assign sout = rd_act_q & oreg_q[NCH-1];

  assert_oe_follows_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pdata_oe |-> $past(!rd_n));

  assert_sout_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sout |-> ($past(!cs_n) && $past(ser_mode)));

  assert_nib_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ser_mode) |-> (snib == '0));

endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import host_port_pkg::*;
#(
  parameter int unsigned BYTE_W = HP_BYTE_W,
  parameter int unsigned NCH    = HP_NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              cmd_sel,
  input  logic [BYTE_W-1:0] pdata_in,
  input  logic              sdata,
  input  logic              sclk,
  input  logic              grp_hi,
  input  logic              stat_sel,
  input  logic [NCH-1:0]    ch_ready,
  input  logic [NCH-1:0]    ch_busy_n,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_is_sub,
  output logic [NCH-1:0]    pdata_out,
  output logic              pdata_oe,
  output logic              sout,
  output logic [NCH/2-1:0]  snib
);

  localparam logic [STB_N-1:0] STB_IDLE = STB_N'(1 << STB_WR);

  logic [STB_N-1:0]  stb_lvl, stb_rise;
  logic              wr_take;
  logic [BYTE_W-1:0] ser_byte;
  byte_tag_e         tag_q;

  always_comb begin
    stb_lvl           = '0;
    stb_lvl[STB_WR]   = wr_n;
    stb_lvl[STB_SCLK] = sclk;
  end

  hp_edge_det #(.N(STB_N), .RST_LVL(STB_IDLE)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (stb_lvl),
    .rise (stb_rise)
  );

  assign wr_take = stb_rise[STB_WR] && !cs_n;

  hp_ser_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ser_mode),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .shift_evt(stb_rise[STB_SCLK]),
    .sd       (sdata),
    .take     (wr_take),
    .shreg    (ser_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      tag_q      <= TAG_CMD;
    end else begin
      byte_valid <= wr_take;
      if (wr_take) begin
        byte_data <= ser_mode ? ser_byte : pdata_in;
        tag_q     <= cmd_sel ? TAG_SUB : TAG_CMD;
      end
    end
  end

  assign byte_is_sub = (tag_q == TAG_SUB);

  hp_stat_out #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_mode (ser_mode),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .shift_evt(stb_rise[STB_SCLK]),
    .stat_sel (stat_sel),
    .grp_hi   (grp_hi),
    .ready    (ch_ready),
    .busy_n   (ch_busy_n),
    .pdata_out(pdata_out),
    .pdata_oe (pdata_oe),
    .sout     (sout),
    .snib     (snib)
  );

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_cs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(!cs_n));

endmodule

// File: tb/tb_host_cmd_port.sv
module tb_host_cmd_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_mode, cs_n, wr_n, rd_n, cmd_sel, sdata, sclk, grp_hi, stat_sel;
  logic [7:0] pdata_in, ch_ready, ch_busy_n;
  logic       byte_valid, byte_is_sub, pdata_oe, sout;
  logic [7:0] byte_data, pdata_out;
  logic [3:0] snib;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_cmd_port dut (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .cs_n(cs_n), .wr_n(wr_n),
    .rd_n(rd_n), .cmd_sel(cmd_sel), .pdata_in(pdata_in), .sdata(sdata),
    .sclk(sclk), .grp_hi(grp_hi), .stat_sel(stat_sel), .ch_ready(ch_ready),
    .ch_busy_n(ch_busy_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_is_sub(byte_is_sub), .pdata_out(pdata_out), .pdata_oe(pdata_oe),
    .sout(sout), .snib(snib)
  );

  typedef struct packed {
    logic       cs_n;
    logic       cmd;
    logic [7:0] d;
  } pvec_t;

  localparam int NVEC = 6;
  localparam pvec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 8'h09},
    '{1'b0, 1'b0, 8'h18},
    '{1'b1, 1'b0, 8'hEE},
    '{1'b0, 1'b1, 8'h25},
    '{1'b1, 1'b1, 8'h77},
    '{1'b0, 1'b0, 8'hF0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // WR low for one cycle then high; returns at the negedge where the pulse is due
  task automatic wr_pulse(input logic cmd);
    cmd_sel = cmd;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sclk_pulse(input logic b);
    sdata = b;
    sclk  = 1'b1;
    @(negedge clk);
    sclk  = 1'b0;
    @(negedge clk);
  endtask

  task automatic ser_byte_bits(input logic [7:0] v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) sclk_pulse(v[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    rst_n = 1'b0; ser_mode = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    cmd_sel = 1'b0; pdata_in = 8'h00; sdata = 1'b0; sclk = 1'b0;
    grp_hi = 1'b0; stat_sel = 1'b1; ch_ready = 8'hA5; ch_busy_n = 8'h3C;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", byte_valid, 0);
    chk("R1 oe", pdata_oe, 0);
    chk("R1 pdata_out", pdata_out, 0);
    chk("R1 sout", sout, 0);
    chk("R1 snib", snib, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", byte_valid, 0);

    // R2 / R3: parallel write table
    last = 8'h00;
    for (int k = 0; k < NVEC; k++) begin
      cs_n = VEC[k].cs_n;
      pdata_in = VEC[k].d;
      wr_pulse(VEC[k].cmd);
      if (!VEC[k].cs_n) begin
        chk("R2 valid", byte_valid, 1);
        chk("R2 data", byte_data, VEC[k].d);
        chk("R2 tag", byte_is_sub, VEC[k].cmd);
        last = VEC[k].d;
      end else begin
        chk("R3 no valid", byte_valid, 0);
        chk("R3 data held", byte_data, last);
      end
      @(negedge clk);
      chk("R11 single pulse", byte_valid, 0);
      cs_n = 1'b1;
      @(negedge clk);
    end

    // R4 serial full byte, parallel bus ignored
    ser_mode = 1'b1;
    pdata_in = 8'hFF;
    cs_n = 1'b0;
    @(negedge clk);
    ser_byte_bits(8'hC3, 8);
    wr_pulse(1'b1);
    chk("R4 valid", byte_valid, 1);
    chk("R4 data", byte_data, 8'hC3);
    chk("R4 tag", byte_is_sub, 1);
    @(negedge clk);
    chk("R11 serial pulse", byte_valid, 0);

    // R5 partial byte of three bits
    ser_byte_bits(8'h05, 3);
    wr_pulse(1'b0);
    chk("R5 partial data", byte_data, 8'h05);
    chk("R5 partial tag", byte_is_sub, 0);

    // R5 CS high discards gathered bits
    ser_byte_bits(8'h03, 2);
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    sclk_pulse(1'b1);
    wr_pulse(1'b1);
    chk("R5 cs clear", byte_data, 8'h01);

    // R6 extra clocks ignored
    ser_byte_bits(8'h96, 8);
    sclk_pulse(1'b1);
    sclk_pulse(1'b1);
    wr_pulse(1'b0);
    chk("R6 overflow", byte_data, 8'h96);
    cs_n = 1'b1;
    @(negedge clk);

    // R10 nibble status
    stat_sel = 1'b1; grp_hi = 1'b1;
    @(negedge clk);
    chk("R10 upper half", snib, 4'hA);
    grp_hi = 1'b0;
    @(negedge clk);
    chk("R10 lower half", snib, 4'h5);
    stat_sel = 1'b0;
    @(negedge clk);
    chk("R10 R8 busy lower", snib, 4'hC);

    // R9 serial status readback
    chk("R9 idle sout", sout, 0);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    ch_busy_n = 8'hFF;
    chk("R9 bit7", sout, 0);
    for (int b = 6; b >= 0; b--) begin
      sclk_pulse(1'b0);
      chk("R9 shifted bit", sout, (8'h3C >> b) & 1);
    end
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk("R9 sout after read", sout, 0);
    ch_busy_n = 8'h3C;

    // R7 / R8 parallel read
    ser_mode = 1'b0;
    @(negedge clk);
    chk("R10 parallel zero", snib, 0);
    stat_sel = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R7 oe", pdata_oe, 1);
    chk("R7 R8 ready", pdata_out, 8'hA5);
    stat_sel = 1'b0;
    @(negedge clk);
    chk("R8 busy", pdata_out, 8'h3C);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R7 oe released", pdata_oe, 0);
    chk("R7 data released", pdata_out, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule